// File: doc/BRIEF.md
# Serial Row Command Packet Receiver

This block sits at the command input of a memory device that shares a narrow row-command bus with its neighbours. A 3-bit lane carries each row command in eight consecutive transfers. The lane is sampled on both edges of the external clock. In this design that is modelled as a sample strobe, `smp_en`, in a clock running at twice the external rate, so one command takes four external cycles. A frame-start marker flags the first transfer. The receiver shifts the transfers into a 24-bit packet and splits off the device, bank and row fields.

No chip-select wire exists. Every device on the bus sees every packet. This one reacts only when the packet's device field equals its programmable identity register. On a match it gives the local bank logic a one-cycle activate request, together with the bank and row numbers. The identity register can be rewritten through a small write port, but only while no packet is being collected.

Packet layout, with the first transfer landing in the top three bits: bits 23:18 are the device number, bits 17:14 the bank, bits 13:5 the row, and bits 4:0 are reserved.

Top module: `row_cmd_rx`

## Requirements
- R1: While `rst_n` is low, `act_pulse`, `act_bank` and `act_row` are all 0.
- R2: A packet is built from eight strobed transfers. The first transfer (the one with `frame_st` high) becomes bits 23:21 and the eighth becomes bits 2:0. The bank is taken from bits 17:14.
- R3: When the eighth transfer is captured and bits 23:18 equal the identity register, `act_pulse` is high for exactly the one cycle after the capturing edge. It is never high for two cycles in a row.
- R4: A completed packet whose device field differs from the identity register gives no pulse, and `act_bank` and `act_row` keep their previous values. These outputs change only together with a pulse.
- R5: A `frame_st` strobed in the middle of a packet discards the partial packet. That transfer then becomes transfer 0 of a new packet, and this includes the case where it lands on the eighth slot.
- R6: Cycles with `smp_en` low change nothing. Strobed transfers while idle without `frame_st` are ignored, so idle cycles may be freely interleaved within a packet.
- R7: A write with `id_we` high is accepted while no packet is in progress and ignored while one is, so a packet under collection is always compared against the identity in force when it began.
- R8: Reserved bits 4:0 have no effect on matching or on the outputs.
- R9: Any bank 0..15 and any row 0..511 (row taken from bits 13:5) is delivered unchanged on `act_bank` and `act_row`.
- R10: The identity register resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate internal clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| smp_en | input | 1 | Transfer strobe, one per command-bus edge |
| frame_st | input | 1 | Marks transfer 0 of a packet (qualified by `smp_en`) |
| cmd_lane | input | 3 | Command bus transfer data |
| id_we | input | 1 | Identity register write enable |
| id_wdata | input | 6 | New identity value |
| act_pulse | output | 1 | One-cycle activate request on an address match |
| act_bank | output | 4 | Bank of the last matching packet |
| act_row | output | 9 | Row of the last matching packet |

## Verification
The corners that are hardest to reach are those where a new `frame_st` lands on the eighth transfer slot, and where an identity write arrives while a packet is half collected. Neither happens with cleanly framed traffic. The bench drives packets with random idle gaps, random aborts at every transfer index and random identity writes inside gaps. A behavioural model tracks the packet, the identity and the expected outputs, and both are compared on every cycle. Directed packets also hit the extreme bank and row values and vary the reserved bits.

// File: rtl/row_cmd_pkg.sv
package row_cmd_pkg;
  localparam int LANE_W = 3;
  localparam int XFERS  = 8;
  localparam int PKT_W  = LANE_W * XFERS;
  localparam int DEV_W  = 6;
  localparam int BANK_W = 4;
  localparam int ROW_W  = 9;
  localparam int RSV_W  = PKT_W - DEV_W - BANK_W - ROW_W;
  localparam int CNT_W  = $clog2(XFERS);

  typedef struct packed {
    logic [DEV_W-1:0]  dev;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [RSV_W-1:0]  rsv;
  } row_pkt_t;
endpackage

// File: rtl/xfer_seq.sv
module xfer_seq
  import row_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en,
  input  logic frame_st,
  output logic busy,
  output logic load_first,
  output logic shift_en,
  output logic last_xfer
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  assign load_first = smp_en & frame_st;
  assign shift_en   = smp_en & ~frame_st & busy_q;
  assign last_xfer  = shift_en & (cnt_q == CNT_W'(XFERS - 1));
  assign busy       = busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (load_first) begin
      cnt_d  = CNT_W'(1);
      busy_d = 1'b1;
    end else if (shift_en) begin
      if (last_xfer) begin
        cnt_d  = '0;
        busy_d = 1'b0;
      end else begin
        cnt_d  = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != '0)) else $error("count out of range"); // R2
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    load_first |=> (busy_q && cnt_q == CNT_W'(1))) else $error("restart"); // R5
  AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !load_first) |=> !busy_q) else $error("idle strobe"); // R6
endmodule

// File: rtl/pkt_shift.sv
module pkt_shift
  import row_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_first,
  input  logic              shift_en,
  input  logic [LANE_W-1:0] cmd_lane,
  output logic [PKT_W-1:0]  pkt_next
);
  logic [PKT_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load_first) begin
      sr_d = {{(PKT_W-LANE_W){1'b0}}, cmd_lane};
    end else if (shift_en) begin
      sr_d = {sr_q[PKT_W-LANE_W-1:0], cmd_lane};
    end
  end

  assign pkt_next = sr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end
endmodule

// File: rtl/id_reg.sv
module id_reg
  import row_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             id_we,
  input  logic [DEV_W-1:0] id_wdata,
  output logic [DEV_W-1:0] id_val
);
  logic [DEV_W-1:0] id_q, id_d;
  logic             wr_ok;

  assign wr_ok = id_we & ~busy;

  always_comb begin
    id_d = id_q;
    if (wr_ok) id_d = id_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) id_q <= '0;
    else        id_q <= id_d;
  end

  assign id_val = id_q;

  AST_ID_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && id_we) |=> $stable(id_q)) else $error("id written mid packet"); // R7
endmodule

// File: rtl/field_match.sv
module field_match
  import row_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last_xfer,
  input  logic [PKT_W-1:0]  pkt_next,
  input  logic [DEV_W-1:0]  id_val,
  output logic              act_pulse,
  output logic [BANK_W-1:0] act_bank,
  output logic [ROW_W-1:0]  act_row
);
  row_pkt_t          pkt;
  logic              hit;
  logic              pulse_q;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [ROW_W-1:0]  row_q, row_d;

  assign pkt = row_pkt_t'(pkt_next);
  assign hit = last_xfer & (pkt.dev == id_val);

  always_comb begin
    bank_d = bank_q;
    row_d  = row_q;
    if (hit) begin
      bank_d = pkt.bank;
      row_d  = pkt.row;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      bank_q  <= '0;
      row_q   <= '0;
    end else begin
      pulse_q <= hit;
      bank_q  <= bank_d;
      row_q   <= row_d;
    end
  end

  assign act_pulse = pulse_q;
  assign act_bank  = bank_q;
  assign act_row   = row_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q) else $error("pulse too long"); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(bank_q) || !$stable(row_q)) |-> pulse_q) else $error("outputs moved"); // R4
endmodule

// File: rtl/row_cmd_rx.sv
module row_cmd_rx
  import row_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic              frame_st,
  input  logic [LANE_W-1:0] cmd_lane,
  input  logic              id_we,
  input  logic [DEV_W-1:0]  id_wdata,
  output logic              act_pulse,
  output logic [BANK_W-1:0] act_bank,
  output logic [ROW_W-1:0]  act_row
);
  logic             busy, load_first, shift_en, last_xfer;
  logic [PKT_W-1:0] pkt_next;
  logic [DEV_W-1:0] id_val;

  xfer_seq u_seq (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .frame_st(frame_st),
    .busy(busy), .load_first(load_first), .shift_en(shift_en),
    .last_xfer(last_xfer)
  );

  pkt_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load_first(load_first), .shift_en(shift_en),
    .cmd_lane(cmd_lane), .pkt_next(pkt_next)
  );

  id_reg u_id (
    .clk(clk), .rst_n(rst_n), .busy(busy), .id_we(id_we),
    .id_wdata(id_wdata), .id_val(id_val)
  );

  field_match u_match (
    .clk(clk), .rst_n(rst_n), .last_xfer(last_xfer), .pkt_next(pkt_next),
    .id_val(id_val), .act_pulse(act_pulse), .act_bank(act_bank),
    .act_row(act_row)
  );

  AST_PULSE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    act_pulse |-> !busy || $past(load_first)) else $error("pulse mid packet"); // R3
endmodule

// File: tb/row_cmd_rx_test.sv
`timescale 1ns/1ps
module row_cmd_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_en = 1'b0;
  logic       frame_st = 1'b0;
  logic [2:0] cmd_lane = '0;
  logic       id_we = 1'b0;
  logic [5:0] id_wdata = '0;
  logic       act_pulse;
  logic [3:0] act_bank;
  logic [8:0] act_row;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  int m_cnt = 0;
  int m_pkt = 0;
  int m_id = 0;
  int e_pulse = 0;
  int e_bank = 0;
  int e_row = 0;
  bit started = 1'b0;

  always #2.5 clk = ~clk;

  row_cmd_rx uut (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .frame_st(frame_st),
    .cmd_lane(cmd_lane), .id_we(id_we), .id_wdata(id_wdata),
    .act_pulse(act_pulse), .act_bank(act_bank), .act_row(act_row)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int was_busy;
    if (!rst_n) begin
      m_cnt = 0; m_pkt = 0; m_id = 0; e_pulse = 0; e_bank = 0; e_row = 0;
    end else begin
      started = 1'b1;
      was_busy = (m_cnt != 0);
      e_pulse = 0;
      if (smp_en && frame_st) begin
        m_pkt = cmd_lane; m_cnt = 1;
      end else if (smp_en && m_cnt != 0) begin
        m_pkt = ((m_pkt << 3) | cmd_lane) & 24'hFFFFFF;
        m_cnt++;
        if (m_cnt == 8) begin
          m_cnt = 0;
          if (((m_pkt >> 18) & 63) == m_id) begin
            e_pulse = 1;
            e_bank = (m_pkt >> 14) & 15;
            e_row = (m_pkt >> 5) & 511;
          end
        end
      end
      if (id_we && !was_busy) m_id = id_wdata;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      check(act_pulse == e_pulse[0], "R3 act_pulse", act_pulse, e_pulse);
      check(act_bank == e_bank[3:0], "R2 act_bank", act_bank, e_bank);
      check(act_row == e_row[8:0], "R9 act_row", act_row, e_row);
    end
  end

  task automatic drive(input bit s, input bit f, input int lane, input bit we, input int wd);
    smp_en = s; frame_st = f; cmd_lane = lane[2:0]; id_we = we; id_wdata = wd[5:0];
    @(negedge clk);
    smp_en = 1'b0; frame_st = 1'b0; id_we = 1'b0;
  endtask

  function automatic int mk(input int dev, input int bank, input int row, input int rsv);
    return (dev << 18) | (bank << 14) | (row << 5) | rsv;
  endfunction

  // sends transfers 0..n-1 of pkt; gaps hold random idle cycles, optionally with id writes
  task automatic send(input int pkt, input int n, input int gap_pct, input bit wr_gap);
    for (int i = 0; i < n; i++) begin
      drive(1'b1, i == 0, (pkt >> (21 - 3 * i)) & 7, 1'b0, 0);
      if (i < n - 1 && $urandom_range(99) < gap_pct)
        drive(1'b0, 1'b0, $urandom_range(7), wr_gap, $urandom_range(63));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs held at zero in reset
    check(act_pulse == 1'b0, "R1 pulse in reset", act_pulse, 0);
    check(act_bank == 4'd0 && act_row == 9'd0, "R1 fields in reset", act_row, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: identity resets to 0, so device 0 matches
    send(mk(0, 5, 300, 0), 8, 0, 1'b0);
    check(act_pulse == 1'b1, "R10 match device 0", act_pulse, 1);
    check(act_bank == 4'd5, "R2 bank field", act_bank, 5);
    check(act_row == 9'd300, "R9 row field", act_row, 300);
    @(negedge clk);
    check(act_pulse == 1'b0, "R3 single cycle", act_pulse, 0);

    // R7: idle write accepted; R4: old id no longer matches, outputs hold
    drive(1'b0, 1'b0, 0, 1'b1, 6'h2A);
    send(mk(0, 9, 17, 0), 8, 0, 1'b0);
    check(act_pulse == 1'b0, "R4 mismatch no pulse", act_pulse, 0);
    check(act_bank == 4'd5 && act_row == 9'd300, "R4 outputs hold", act_row, 300);

    // R9 + R6: extreme fields with idle gaps
    send(mk(6'h2A, 15, 511, 31), 8, 60, 1'b0);
    check(act_pulse == 1'b1, "R6 gaps ignored", act_pulse, 1);
    check(act_bank == 4'd15 && act_row == 9'd511, "R9 max fields", act_row, 511);
    @(negedge clk);

    // R8: reserved bits irrelevant
    send(mk(6'h2A, 0, 0, 5'h15), 8, 0, 1'b0);
    check(act_pulse == 1'b1 && act_bank == 4'd0 && act_row == 9'd0, "R8 reserved ignored", act_row, 0);
    @(negedge clk);

    // R7: write during packet ignored
    send(mk(6'h2A, 3, 100, 0), 4, 0, 1'b0);
    drive(1'b0, 1'b0, 0, 1'b1, 6'h11);
    begin
      int p = mk(6'h2A, 3, 100, 0);
      for (int i = 4; i < 8; i++) drive(1'b1, 1'b0, (p >> (21 - 3 * i)) & 7, 1'b0, 0);
    end
    check(act_pulse == 1'b1 && act_bank == 4'd3, "R7 busy write ignored", act_bank, 3);
    @(negedge clk);

    // R5: restart mid packet, and on the eighth slot
    send(mk(6'h3F, 1, 1, 0), 5, 0, 1'b0);
    send(mk(6'h2A, 7, 77, 0), 8, 0, 1'b0);
    check(act_pulse == 1'b1 && act_row == 9'd77, "R5 restart", act_row, 77);
    send(mk(6'h2A, 2, 2, 0), 7, 0, 1'b0);
    send(mk(6'h2A, 6, 66, 0), 8, 0, 1'b0);
    check(act_pulse == 1'b1 && act_row == 9'd66, "R5 restart on slot 8", act_row, 66);
    @(negedge clk);

    // R6: strobes without frame while idle do nothing
    begin
      int p = mk(6'h2A, 12, 200, 0);
      for (int i = 0; i < 8; i++) drive(1'b1, 1'b0, (p >> (21 - 3 * i)) & 7, 1'b0, 0);
    end
    @(negedge clk);
    check(act_pulse == 1'b0 && act_row == 9'd66, "R6 idle strobes", act_row, 66);

    // random traffic against the model
    for (int k = 0; k < 400; k++) begin
      int dev = ($urandom_range(1)) ? m_id : $urandom_range(63);
      int p = mk(dev, $urandom_range(15), $urandom_range(511), $urandom_range(31));
      int n = ($urandom_range(3) == 0) ? $urandom_range(1, 8) : 8;
      send(p, n, 30, $urandom_range(1));
      if ($urandom_range(4) == 0) drive(1'b0, 1'b0, 0, 1'b1, ($urandom_range(1)) ? m_id : $urandom_range(63));
    end
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule